// File: doc/BRIEF.md
# Subchannel Engine Dispatch Router

The router takes a stream of register writes, each carrying a method index, a 3-bit subchannel number and a 32-bit value, and sends each one on to the engine that the subchannel has been tied to. A write with method 0 ties, or binds, a subchannel to an engine class. It stores the low 16 bits of the value in that subchannel's binding entry. Later writes with method 0x100 or above on that subchannel reach whichever of three engine ports the bound class selects: 2D, 3D or compute. Routing is therefore indirect, because the subchannel alone never names an engine.

Methods 1 to 0xFF are reserved and are absorbed locally. Binding mistakes and writes the block cannot serve raise three sticky status flags, which a pulse on `flag_clr` clears. A two-state controller sequences the work. In `ST_IDLE` the input is ready, and an accepted write (transition `ACCEPT`) is captured and moves the controller to `ST_EXEC`. In `ST_EXEC` the captured write is classified and acted on: a table write, a flag, or a one-cycle pulse on one engine port. The controller then always returns to `ST_IDLE` (transition `RETIRE`). If no write is offered, `ST_IDLE` stays put (transition `WAIT`).

Top module: `subch_dispatch_router`

## Requirements
- R1: After reset every subchannel is unbound, all three flags are low, `wr_ready` is high and no engine valid is asserted.
- R2: A write is accepted on a clock edge where `wr_valid` and `wr_ready` are both high. `wr_ready` is low for the following cycle and high again one cycle later, so the block takes at most one write every two cycles.
- R3: A write with method 0 to an unbound subchannel stores bits 15:0 of its value as that subchannel's class and forwards nothing.
- R4: A method-0 write to an already bound subchannel sets `err_rebind` and leaves the existing binding unchanged.
- R5: Methods 1 through 0xFF are never forwarded and set `unimpl`. Method 0xFF is reserved, and 0x100 is the first forwarded method.
- R6: A write with method 0x100 or above is forwarded on a bound subchannel as follows: class 0x902D goes to the `eng2d` port, 0xB197 to the `eng3d` port and 0xB1C0 to the `engcmp` port. The method and value arrive unchanged, and the port's valid is high for exactly the one cycle that follows the cycle after acceptance.
- R7: A write with method 0x100 or above to an unbound subchannel sets `err_unbound` and is dropped.
- R8: A write with method 0x100 or above to a subchannel bound to 0xA140, 0xB0B5 or any other unlisted class sets `unimpl` and is dropped.
- R9: Each flag stays high once set until `flag_clr` is high at a clock edge, which clears all three flags at that edge.
- R10: Subchannel bindings are independent of one another, and at most one engine valid is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write offered |
| wr_ready | output | 1 | Router can accept a write |
| wr_method | input | 13 | Method index |
| wr_subch | input | 3 | Subchannel number |
| wr_value | input | 32 | Write value |
| flag_clr | input | 1 | Clears all sticky flags |
| eng2d_valid | output | 1 | 2D engine write strobe |
| eng2d_method | output | 13 | 2D engine method |
| eng2d_value | output | 32 | 2D engine value |
| eng3d_valid | output | 1 | 3D engine write strobe |
| eng3d_method | output | 13 | 3D engine method |
| eng3d_value | output | 32 | 3D engine value |
| engcmp_valid | output | 1 | Compute engine write strobe |
| engcmp_method | output | 13 | Compute engine method |
| engcmp_value | output | 32 | Compute engine value |
| err_rebind | output | 1 | Sticky: bind to an already bound subchannel |
| err_unbound | output | 1 | Sticky: write to an unbound subchannel |
| unimpl | output | 1 | Sticky: reserved method or unserved class |

## Verification
Every result of a write is due two edges after the write is offered. The first edge accepts the write. The second edge registers the engine strobe, the flag update and the binding update together. The bench drives inputs on falling edges and checks `wr_ready` low one half-cycle after acceptance. It samples all ports at the falling edge that follows the second rising edge, and it samples again one cycle later to confirm that the strobe has dropped. Bindings are checked only through their effect on later writes at the ports.

// File: rtl/sdr_pkg.sv
package sdr_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_EXEC = 1'b1
    } state_t;

    typedef enum logic [2:0] {
        RT_BIND,
        RT_REBIND,
        RT_RESERVED,
        RT_UNBOUND,
        RT_TO_2D,
        RT_TO_3D,
        RT_TO_CMP,
        RT_UNSERVED
    } route_t;

    localparam logic [15:0] CLS_2D  = 16'h902D;
    localparam logic [15:0] CLS_3D  = 16'hB197;
    localparam logic [15:0] CLS_CMP = 16'hB1C0;
    localparam logic [15:0] CLS_I2M = 16'hA140;
    localparam logic [15:0] CLS_DMA = 16'hB0B5;

    localparam int ENG_2D  = 0;
    localparam int ENG_3D  = 1;
    localparam int ENG_CMP = 2;
    localparam int NUM_ENG = 3;

    localparam int FLAG_REBIND  = 0;
    localparam int FLAG_UNBOUND = 1;
    localparam int FLAG_UNIMPL  = 2;
    localparam int NUM_FLAG     = 3;

endpackage

// File: rtl/sdr_bind_table.sv
module sdr_bind_table #(
    parameter int IDX_W = 3,
    parameter int CLS_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_bound,
    output logic [CLS_W-1:0] rd_class,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [CLS_W-1:0] wr_class
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DEPTH-1:0] bound_q;
    logic [CLS_W-1:0] class_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bound_q[i] <= 1'b0;
                class_q[i] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(i)) && !bound_q[i]) begin
                bound_q[i] <= 1'b1;
                class_q[i] <= wr_class;
            end
        end

        // R4
        binding_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
            bound_q[i] |=> (bound_q[i] && (class_q[i] == $past(class_q[i]))));
    end

    assign rd_bound = bound_q[rd_idx];
    assign rd_class = class_q[rd_idx];

endmodule

// File: rtl/sdr_classify.sv
module sdr_classify
    import sdr_pkg::*;
#(
    parameter int METHOD_W       = 13,
    parameter int CLS_W          = 16,
    parameter int RESERVED_LIMIT = 256
) (
    input  logic [METHOD_W-1:0] method,
    input  logic                bound,
    input  logic [CLS_W-1:0]    cls,
    output route_t              route
);
    logic is_bind;
    logic is_reserved;

    assign is_bind     = (method == '0);
    assign is_reserved = (method < METHOD_W'(RESERVED_LIMIT));

    always_comb begin
        route = RT_UNSERVED;
        if (is_bind) begin
            route = bound ? RT_REBIND : RT_BIND;
        end else if (is_reserved) begin
            route = RT_RESERVED;
        end else if (!bound) begin
            route = RT_UNBOUND;
        end else begin
            unique case (cls)
                CLS_W'(CLS_2D):  route = RT_TO_2D;
                CLS_W'(CLS_3D):  route = RT_TO_3D;
                CLS_W'(CLS_CMP): route = RT_TO_CMP;
                CLS_W'(CLS_I2M),
                CLS_W'(CLS_DMA): route = RT_UNSERVED;
                default:         route = RT_UNSERVED;
            endcase
        end
    end

endmodule

// File: rtl/sdr_engine_port.sv
module sdr_engine_port #(
    parameter int METHOD_W = 13,
    parameter int DATA_W   = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fire,
    input  logic [METHOD_W-1:0] method_in,
    input  logic [DATA_W-1:0]   value_in,
    output logic                out_valid,
    output logic [METHOD_W-1:0] out_method,
    output logic [DATA_W-1:0]   out_value
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_method <= '0;
            out_value  <= '0;
        end else begin
            out_valid <= fire;
            if (fire) begin
                out_method <= method_in;
                out_value  <= value_in;
            end
        end
    end

    // R6
    one_cycle_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

endmodule

// File: rtl/sdr_sticky_flags.sv
module sdr_sticky_flags #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [N-1:0] set,
    output logic [N-1:0] q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= (q & ~{N{clr}}) | set;
        end
    end

    // R9
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((q & $past(q)) == $past(q)));

endmodule

// File: rtl/subch_dispatch_router.sv
module subch_dispatch_router
    import sdr_pkg::*;
#(
    parameter int METHOD_W       = 13,
    parameter int SUBCH_W        = 3,
    parameter int DATA_W         = 32,
    parameter int CLS_W          = 16,
    parameter int RESERVED_LIMIT = 256
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_valid,
    output logic                wr_ready,
    input  logic [METHOD_W-1:0] wr_method,
    input  logic [SUBCH_W-1:0]  wr_subch,
    input  logic [DATA_W-1:0]   wr_value,
    input  logic                flag_clr,
    output logic                eng2d_valid,
    output logic [METHOD_W-1:0] eng2d_method,
    output logic [DATA_W-1:0]   eng2d_value,
    output logic                eng3d_valid,
    output logic [METHOD_W-1:0] eng3d_method,
    output logic [DATA_W-1:0]   eng3d_value,
    output logic                engcmp_valid,
    output logic [METHOD_W-1:0] engcmp_method,
    output logic [DATA_W-1:0]   engcmp_value,
    output logic                err_rebind,
    output logic                err_unbound,
    output logic                unimpl
);
    state_t state_q, state_d;

    logic [METHOD_W-1:0] cap_method;
    logic [SUBCH_W-1:0]  cap_subch;
    logic [DATA_W-1:0]   cap_value;
    logic                accept;

    logic                tbl_bound;
    logic [CLS_W-1:0]    tbl_class;
    logic                tbl_wr;
    route_t              route;

    logic [NUM_ENG-1:0]  eng_fire;
    logic [NUM_ENG-1:0]  eng_valid;
    logic [METHOD_W-1:0] eng_method [NUM_ENG];
    logic [DATA_W-1:0]   eng_value  [NUM_ENG];
    logic [NUM_FLAG-1:0] flag_set;
    logic [NUM_FLAG-1:0] flag_q;

    assign accept = wr_valid && wr_ready;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept) state_d = ST_EXEC;
            ST_EXEC: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_method <= '0;
            cap_subch  <= '0;
            cap_value  <= '0;
        end else if (accept) begin
            cap_method <= wr_method;
            cap_subch  <= wr_subch;
            cap_value  <= wr_value;
        end
    end

    sdr_bind_table #(
        .IDX_W (SUBCH_W),
        .CLS_W (CLS_W)
    ) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (cap_subch),
        .rd_bound (tbl_bound),
        .rd_class (tbl_class),
        .wr_en    (tbl_wr),
        .wr_idx   (cap_subch),
        .wr_class (cap_value[CLS_W-1:0])
    );

    sdr_classify #(
        .METHOD_W       (METHOD_W),
        .CLS_W          (CLS_W),
        .RESERVED_LIMIT (RESERVED_LIMIT)
    ) u_classify (
        .method (cap_method),
        .bound  (tbl_bound),
        .cls    (tbl_class),
        .route  (route)
    );

    // output process
    always_comb begin
        wr_ready = 1'b0;
        tbl_wr   = 1'b0;
        eng_fire = '0;
        flag_set = '0;
        unique case (state_q)
            ST_IDLE: wr_ready = 1'b1;
            ST_EXEC: begin
                unique case (route)
                    RT_BIND:     tbl_wr = 1'b1;
                    RT_REBIND:   flag_set[FLAG_REBIND]  = 1'b1;
                    RT_RESERVED: flag_set[FLAG_UNIMPL]  = 1'b1;
                    RT_UNBOUND:  flag_set[FLAG_UNBOUND] = 1'b1;
                    RT_TO_2D:    eng_fire[ENG_2D]  = 1'b1;
                    RT_TO_3D:    eng_fire[ENG_3D]  = 1'b1;
                    RT_TO_CMP:   eng_fire[ENG_CMP] = 1'b1;
                    RT_UNSERVED: flag_set[FLAG_UNIMPL]  = 1'b1;
                    default:     flag_set[FLAG_UNIMPL]  = 1'b1;
                endcase
            end
            default: wr_ready = 1'b0;
        endcase
    end

    for (genvar e = 0; e < NUM_ENG; e++) begin : g_port
        sdr_engine_port #(
            .METHOD_W (METHOD_W),
            .DATA_W   (DATA_W)
        ) u_port (
            .clk        (clk),
            .rst_n      (rst_n),
            .fire       (eng_fire[e]),
            .method_in  (cap_method),
            .value_in   (cap_value),
            .out_valid  (eng_valid[e]),
            .out_method (eng_method[e]),
            .out_value  (eng_value[e])
        );
    end

    sdr_sticky_flags #(
        .N (NUM_FLAG)
    ) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (flag_clr),
        .set   (flag_set),
        .q     (flag_q)
    );

    assign eng2d_valid   = eng_valid[ENG_2D];
    assign eng2d_method  = eng_method[ENG_2D];
    assign eng2d_value   = eng_value[ENG_2D];
    assign eng3d_valid   = eng_valid[ENG_3D];
    assign eng3d_method  = eng_method[ENG_3D];
    assign eng3d_value   = eng_value[ENG_3D];
    assign engcmp_valid  = eng_valid[ENG_CMP];
    assign engcmp_method = eng_method[ENG_CMP];
    assign engcmp_value  = eng_value[ENG_CMP];
    assign err_rebind    = flag_q[FLAG_REBIND];
    assign err_unbound   = flag_q[FLAG_UNBOUND];
    assign unimpl        = flag_q[FLAG_UNIMPL];

    // R2
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !wr_ready);

    // R2
    ready_returns_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ready |=> wr_ready);

    // R10
    single_engine_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(eng_valid));

    // R7
    unbound_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EXEC && !tbl_bound) |=> (eng_valid == '0));

    // R6
    strobe_needs_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |=> (eng_valid == '0));

endmodule

// File: tb/subch_dispatch_router_tb.sv
module subch_dispatch_router_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic        wr_ready;
    logic [12:0] wr_method = '0;
    logic [2:0]  wr_subch = '0;
    logic [31:0] wr_value = '0;
    logic        flag_clr = 1'b0;
    logic        eng2d_valid, eng3d_valid, engcmp_valid;
    logic [12:0] eng2d_method, eng3d_method, engcmp_method;
    logic [31:0] eng2d_value, eng3d_value, engcmp_value;
    logic        err_rebind, err_unbound, unimpl;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    logic        s_v [3];
    logic [12:0] s_m [3];
    logic [31:0] s_d [3];

    always #5 clk = ~clk;

    subch_dispatch_router dut_i (
        .clk (clk), .rst_n (rst_n),
        .wr_valid (wr_valid), .wr_ready (wr_ready),
        .wr_method (wr_method), .wr_subch (wr_subch), .wr_value (wr_value),
        .flag_clr (flag_clr),
        .eng2d_valid (eng2d_valid), .eng2d_method (eng2d_method), .eng2d_value (eng2d_value),
        .eng3d_valid (eng3d_valid), .eng3d_method (eng3d_method), .eng3d_value (eng3d_value),
        .engcmp_valid (engcmp_valid), .engcmp_method (engcmp_method), .engcmp_value (engcmp_value),
        .err_rebind (err_rebind), .err_unbound (err_unbound), .unimpl (unimpl)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_flags(input string req, input logic rb, input logic ub, input logic ui);
        check(req, "flags {rebind,unbound,unimpl}",
              {29'd0, err_rebind, err_unbound, unimpl}, {29'd0, rb, ub, ui});
    endtask

    // Offer one write, check ready drops, snapshot ports two edges later,
    // then confirm the strobe lasted one cycle.
    task automatic send(input logic [12:0] m, input logic [2:0] sc, input logic [31:0] v);
        @(negedge clk);
        wr_valid = 1'b1; wr_method = m; wr_subch = sc; wr_value = v;
        while (!wr_ready) @(negedge clk);
        @(negedge clk);
        wr_valid = 1'b0;
        check("R2", "ready after accept", {31'd0, wr_ready}, 32'd0);
        @(negedge clk);
        s_v[0] = eng2d_valid;  s_m[0] = eng2d_method;  s_d[0] = eng2d_value;
        s_v[1] = eng3d_valid;  s_m[1] = eng3d_method;  s_d[1] = eng3d_value;
        s_v[2] = engcmp_valid; s_m[2] = engcmp_method; s_d[2] = engcmp_value;
        check("R2", "ready back", {31'd0, wr_ready}, 32'd1);
    endtask

    task automatic expect_route(input string req, input int eng,
                                input logic [12:0] m, input logic [31:0] v);
        for (int e = 0; e < 3; e++) begin
            check(req, $sformatf("engine %0d valid", e), {31'd0, s_v[e]}, {31'd0, (e == eng)});
            if (e == eng) begin
                check(req, "method", {19'd0, s_m[e]}, {19'd0, m});
                check(req, "value", s_d[e], v);
            end
        end
        @(negedge clk);
        check("R6", "strobe dropped", {29'd0, eng2d_valid, eng3d_valid, engcmp_valid}, 32'd0);
    endtask

    task automatic pulse_clear();
        @(negedge clk); flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
    endtask

    task automatic t_reset();
        check("R1", "ready", {31'd0, wr_ready}, 32'd1);
        check("R1", "engine valids", {29'd0, eng2d_valid, eng3d_valid, engcmp_valid}, 32'd0);
        check_flags("R1", 0, 0, 0);
        send(13'h200, 3'd6, 32'h1111_2222);
        expect_route("R1", -1, '0, '0);
        check_flags("R1", 0, 1, 0);
        pulse_clear();
        check_flags("R9", 0, 0, 0);
    endtask

    task automatic t_bind_route();
        send(13'h0, 3'd0, 32'h0000_902D);
        expect_route("R3", -1, '0, '0);
        check_flags("R3", 0, 0, 0);
        send(13'h0, 3'd1, 32'hABCD_B197);
        expect_route("R3", -1, '0, '0);
        send(13'h0, 3'd2, 32'h0000_B1C0);
        send(13'h100, 3'd0, 32'hDEAD_BEEF);
        expect_route("R6", 0, 13'h100, 32'hDEAD_BEEF);
        send(13'h1234, 3'd1, 32'h0102_0304);
        expect_route("R6", 1, 13'h1234, 32'h0102_0304);
        send(13'h1FFF, 3'd2, 32'hFFFF_0000);
        expect_route("R6", 2, 13'h1FFF, 32'hFFFF_0000);
        send(13'h305, 3'd0, 32'h5A5A_A5A5);
        expect_route("R10", 0, 13'h305, 32'h5A5A_A5A5);
        check_flags("R6", 0, 0, 0);
    endtask

    task automatic t_rebind();
        send(13'h0, 3'd0, 32'h0000_B197);
        expect_route("R4", -1, '0, '0);
        check_flags("R4", 1, 0, 0);
        send(13'h140, 3'd0, 32'h7777_7777);
        expect_route("R4", 0, 13'h140, 32'h7777_7777);
    endtask

    task automatic t_reserved();
        pulse_clear();
        send(13'h0FF, 3'd0, 32'h1);
        expect_route("R5", -1, '0, '0);
        check_flags("R5", 0, 0, 1);
        pulse_clear();
        send(13'h001, 3'd1, 32'h2);
        expect_route("R5", -1, '0, '0);
        check_flags("R5", 0, 0, 1);
    endtask

    task automatic t_unbound();
        pulse_clear();
        send(13'h100, 3'd7, 32'h3);
        expect_route("R7", -1, '0, '0);
        check_flags("R7", 0, 1, 0);
    endtask

    task automatic t_unserved();
        send(13'h0, 3'd3, 32'h0000_A140);
        send(13'h0, 3'd4, 32'h0000_B0B5);
        send(13'h0, 3'd5, 32'h0000_1234);
        pulse_clear();
        check_flags("R9", 0, 0, 0);
        send(13'h100, 3'd3, 32'h4);
        expect_route("R8", -1, '0, '0);
        check_flags("R8", 0, 0, 1);
        pulse_clear();
        send(13'h100, 3'd4, 32'h5);
        expect_route("R8", -1, '0, '0);
        check_flags("R8", 0, 0, 1);
        pulse_clear();
        send(13'h100, 3'd5, 32'h6);
        expect_route("R8", -1, '0, '0);
        check_flags("R8", 0, 0, 1);
    endtask

    task automatic t_sticky();
        pulse_clear();
        send(13'h100, 3'd6, 32'h7);
        send(13'h0, 3'd1, 32'h0000_902D);
        send(13'h010, 3'd1, 32'h8);
        repeat (3) @(negedge clk);
        check_flags("R9", 1, 1, 1);
        send(13'h400, 3'd2, 32'h9);
        expect_route("R9", 2, 13'h400, 32'h9);
        check_flags("R9", 1, 1, 1);
        pulse_clear();
        check_flags("R9", 0, 0, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_bind_route();
        t_rebind();
        t_reserved();
        t_unbound();
        t_unserved();
        t_sticky();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule